// File: doc/BRIEF.md
# Matrix Operand Routing Switch

This block sits between a wide data-memory word and an arithmetic core. One memory word carries every variable of a single OFDM subchannel, arranged as `NMAT` square complex matrices of size `NRX`×`NRX`. Two independent read ports each select one matrix and then a vector inside it: a row, a column, the main diagonal or the anti-diagonal. The selected vector is presented to the core as an operand.

A mirror path does the reverse. It takes a result vector from the core and writes it into the chosen vector slots of the chosen matrix. Every other element of the word passes through unchanged, so the merged word is ready to be written back to memory.

All selections come straight from instruction fields. The switch is combinational, and a parameter adds one output register stage, which is on by default.

Top module: `opnd_route_switch`

## Requirements
- R1: While `rst` is high at a rising clock edge, every registered output (`opa_o`, `opb_o`, `word_o`) is zero after that edge.
- R2: Element layout and row shape. Matrix m, row r, column c occupies element `(m*NRX + r)*NRX + c` of the word. Each element is `CW = 2*EW` bits wide, with the real part in the low `EW` bits and the imaginary part in the high bits. Vector element k sits at bits `[k*CW +: CW]`. Shape code 0 (row) returns element k = (idx, k).
- R3: Shape code 1 (column) returns element k = (k, idx).
- R4: Shape code 2 (main diagonal) returns element k = (k, k), and the index field is ignored.
- R5: Shape code 3 (anti-diagonal) returns element k = (k, NRX-1-k), and the index field is ignored.
- R6: The matrix field picks which of the `NMAT` matrices the shape is applied to.
- R7: Ports A and B select independently, and both deliver their vectors in the same cycle from the same word.
- R8: With `wr_en` high, `res_i` element k replaces exactly the slot that read shape/idx would return as element k, inside matrix `wr_mat`.
- R9: With `wr_en` high, every element outside the selected slots, including all elements of other matrices, appears in `word_o` equal to `word_i`.
- R10: With `wr_en` low, `word_o` equals `word_i`.
- R11: With `OUT_REG=1`, every output reflects the inputs present at the previous rising edge and holds its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | NMAT*NRX*NRX*2*EW | Subchannel memory word |
| a_mat | input | clog2(NMAT) | Port A matrix select |
| a_shape | input | 2 | Port A shape: 0 row, 1 column, 2 diagonal, 3 anti-diagonal |
| a_idx | input | clog2(NRX) | Port A row/column index |
| b_mat | input | clog2(NMAT) | Port B matrix select |
| b_shape | input | 2 | Port B shape |
| b_idx | input | clog2(NRX) | Port B row/column index |
| res_i | input | NRX*2*EW | Core result vector to pack |
| wr_en | input | 1 | Enable replacement of selected slots |
| wr_mat | input | clog2(NMAT) | Destination matrix |
| wr_shape | input | 2 | Destination shape |
| wr_idx | input | clog2(NRX) | Destination row/column index |
| opa_o | output | NRX*2*EW | Operand vector A |
| opb_o | output | NRX*2*EW | Operand vector B |
| word_o | output | NMAT*NRX*NRX*2*EW | Merged word for write-back |

## Verification
With the default output stage, both operand vectors and the merged word are due exactly one rising edge after their select fields, result vector and word are applied. The bench therefore drives every stimulus on a falling edge and compares on the next falling edge, with the capturing edge in between. One directed case samples just before that edge to confirm the old values still hold, then samples just after it for the new values. Reset is checked one edge after it is raised, both at start-up and in the middle of traffic.

// File: rtl/opr_pkg.sv
package opr_pkg;

    typedef enum logic [1:0] {
        SH_ROW  = 2'd0,
        SH_COL  = 2'd1,
        SH_DIAG = 2'd2,
        SH_ANTI = 2'd3
    } shape_e;

    // True when element (r,c) of an nrx-square matrix belongs to the vector
    function automatic logic slot_hit(shape_e s, int idx, int r, int c, int nrx);
        case (s)
            SH_ROW:  return r == idx;
            SH_COL:  return c == idx;
            SH_DIAG: return r == c;
            default: return c == (nrx - 1 - r);
        endcase
    endfunction

    // Vector position that element (r,c) takes for a given shape
    function automatic int slot_k(shape_e s, int r, int c);
        return (s == SH_ROW) ? c : r;
    endfunction

endpackage

// File: rtl/opr_extract.sv
module opr_extract
    import opr_pkg::*;
#(
    parameter int NMAT  = 4,
    parameter int NRX   = 4,
    parameter int CW    = 32,
    localparam int MAT_W = (NMAT > 1) ? $clog2(NMAT) : 1,
    localparam int IDX_W = (NRX > 1) ? $clog2(NRX) : 1
) (
    input  logic [CW-1:0]    el    [NMAT][NRX][NRX],
    input  logic [MAT_W-1:0] mat_i,
    input  logic [1:0]       shape_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [CW-1:0]    vec   [NRX]
);
    // Level one: matrix select
    logic [CW-1:0] mat_el [NRX][NRX];
    shape_e        shp;

    assign shp = shape_e'(shape_i);

    always_comb begin
        mat_el = el[mat_i];
    end

    // Level two: vector select inside the matrix
    for (genvar k = 0; k < NRX; k++) begin : g_lane
        always_comb begin
            vec[k] = '0;
            for (int r = 0; r < NRX; r++) begin
                for (int c = 0; c < NRX; c++) begin
                    if (slot_hit(shp, int'(idx_i), r, c, NRX) && slot_k(shp, r, c) == k)
                        vec[k] = mat_el[r][c];
                end
            end
        end
    end

    always_comb begin
        if (!$isunknown({shape_i, mat_i}) && shp == SH_DIAG)
            AST_DIAG_ORIGIN: assert (vec[0] == el[mat_i][0][0])
                else $error("diagonal lane 0 is not element (0,0)"); // R4
    end

    always_comb begin
        if (!$isunknown({shape_i, mat_i}) && shp == SH_ANTI)
            AST_ANTI_CORNER: assert (vec[0] == el[mat_i][0][NRX-1])
                else $error("anti-diagonal lane 0 is not element (0,NRX-1)"); // R5
    end

endmodule

// File: rtl/opr_merge.sv
module opr_merge
    import opr_pkg::*;
#(
    parameter int NMAT  = 4,
    parameter int NRX   = 4,
    parameter int CW    = 32,
    localparam int MAT_W = (NMAT > 1) ? $clog2(NMAT) : 1,
    localparam int IDX_W = (NRX > 1) ? $clog2(NRX) : 1
) (
    input  logic [CW-1:0]    el_i  [NMAT][NRX][NRX],
    input  logic [CW-1:0]    res   [NRX],
    input  logic             wr_en,
    input  logic [MAT_W-1:0] wr_mat,
    input  logic [1:0]       wr_shape,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [CW-1:0]    el_o  [NMAT][NRX][NRX]
);
    shape_e shp;
    assign shp = shape_e'(wr_shape);

    for (genvar m = 0; m < NMAT; m++) begin : g_mat
        for (genvar r = 0; r < NRX; r++) begin : g_row
            for (genvar c = 0; c < NRX; c++) begin : g_col
                logic hit;
                assign hit = wr_en && (wr_mat == MAT_W'(m))
                             && slot_hit(shp, int'(wr_idx), r, c, NRX);
                always_comb begin
                    el_o[m][r][c] = el_i[m][r][c];
                    if (hit)
                        el_o[m][r][c] = res[slot_k(shp, r, c)];
                end
            end
        end

        always_comb begin
            if (!$isunknown({wr_en, wr_mat}) && (!wr_en || wr_mat != MAT_W'(m)))
                AST_OTHER_MAT_KEPT: assert (el_o[m] == el_i[m])
                    else $error("untargeted matrix %0d altered", m); // R9
        end
    end

    always_comb begin
        if (!$isunknown(wr_en) && !wr_en)
            AST_PASS_WHEN_IDLE: assert (el_o == el_i)
                else $error("word altered with write disabled"); // R10
    end

endmodule

// File: rtl/opnd_route_switch.sv
module opnd_route_switch
    import opr_pkg::*;
#(
    parameter int NMAT    = 4,
    parameter int NRX     = 4,
    parameter int EW      = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int CW     = 2 * EW,
    localparam int VEC_W  = NRX * CW,
    localparam int WORD_W = NMAT * NRX * NRX * CW,
    localparam int MAT_W  = (NMAT > 1) ? $clog2(NMAT) : 1,
    localparam int IDX_W  = (NRX > 1) ? $clog2(NRX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic [MAT_W-1:0]  a_mat,
    input  logic [1:0]        a_shape,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [MAT_W-1:0]  b_mat,
    input  logic [1:0]        b_shape,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [VEC_W-1:0]  res_i,
    input  logic              wr_en,
    input  logic [MAT_W-1:0]  wr_mat,
    input  logic [1:0]        wr_shape,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic [VEC_W-1:0]  opa_o,
    output logic [VEC_W-1:0]  opb_o,
    output logic [WORD_W-1:0] word_o
);
    logic [CW-1:0]     el_in  [NMAT][NRX][NRX];
    logic [CW-1:0]     el_out [NMAT][NRX][NRX];
    logic [CW-1:0]     va     [NRX];
    logic [CW-1:0]     vb     [NRX];
    logic [CW-1:0]     rv     [NRX];
    logic [VEC_W-1:0]  opa_c, opb_c;
    logic [WORD_W-1:0] word_c;

    // Unpack / repack the flat word: element (m,r,c) at (m*NRX+r)*NRX+c
    for (genvar m = 0; m < NMAT; m++) begin : g_m
        for (genvar r = 0; r < NRX; r++) begin : g_r
            for (genvar c = 0; c < NRX; c++) begin : g_c
                localparam int POS = ((m * NRX + r) * NRX + c) * CW;
                assign el_in[m][r][c]       = word_i[POS +: CW];
                assign word_c[POS +: CW]    = el_out[m][r][c];
            end
        end
    end

    for (genvar k = 0; k < NRX; k++) begin : g_v
        assign opa_c[k*CW +: CW] = va[k];
        assign opb_c[k*CW +: CW] = vb[k];
        assign rv[k]             = res_i[k*CW +: CW];
    end

    opr_extract #(.NMAT(NMAT), .NRX(NRX), .CW(CW)) u_rd_a (
        .el(el_in), .mat_i(a_mat), .shape_i(a_shape), .idx_i(a_idx), .vec(va)
    );

    opr_extract #(.NMAT(NMAT), .NRX(NRX), .CW(CW)) u_rd_b (
        .el(el_in), .mat_i(b_mat), .shape_i(b_shape), .idx_i(b_idx), .vec(vb)
    );

    opr_merge #(.NMAT(NMAT), .NRX(NRX), .CW(CW)) u_wr (
        .el_i(el_in), .res(rv), .wr_en(wr_en), .wr_mat(wr_mat),
        .wr_shape(wr_shape), .wr_idx(wr_idx), .el_o(el_out)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                opa_o  <= '0;
                opb_o  <= '0;
                word_o <= '0;
            end else begin
                opa_o  <= opa_c;
                opb_o  <= opb_c;
                word_o <= word_c;
            end
        end

        AST_OPA_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> opa_o == $past(opa_c)); // R11
        AST_OPB_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> opb_o == $past(opb_c)); // R11
        AST_WORD_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> word_o == $past(word_c)); // R11
        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> (opa_o == '0 && opb_o == '0 && word_o == '0)); // R1
    end else begin : g_comb
        assign opa_o  = opa_c;
        assign opb_o  = opb_c;
        assign word_o = word_c;
    end

endmodule

// File: tb/opnd_route_switch_tb.sv
module opnd_route_switch_tb;
    localparam int NMAT   = 4;
    localparam int NRX    = 4;
    localparam int EW     = 16;
    localparam int CW     = 2 * EW;
    localparam int VEC_W  = NRX * CW;
    localparam int WORD_W = NMAT * NRX * NRX * CW;
    localparam int NTV    = 10;

    // {a_mat,a_shape,a_idx, b_mat,b_shape,b_idx, wr_en, wr_mat,wr_shape,wr_idx}
    localparam logic [18:0] TV [NTV] = '{
        {2'd0,2'd0,2'd0, 2'd3,2'd0,2'd3, 1'b1, 2'd0,2'd0,2'd2},
        {2'd1,2'd1,2'd2, 2'd2,2'd1,2'd0, 1'b1, 2'd1,2'd1,2'd3},
        {2'd2,2'd2,2'd0, 2'd0,2'd3,2'd0, 1'b1, 2'd0,2'd2,2'd0},
        {2'd3,2'd3,2'd1, 2'd3,2'd2,2'd3, 1'b1, 2'd3,2'd3,2'd0},
        {2'd0,2'd1,2'd3, 2'd1,2'd0,2'd1, 1'b1, 2'd3,2'd0,2'd3},
        {2'd2,2'd0,2'd2, 2'd2,2'd1,2'd2, 1'b0, 2'd2,2'd0,2'd1},
        {2'd1,2'd3,2'd2, 2'd1,2'd2,2'd1, 1'b1, 2'd2,2'd1,2'd0},
        {2'd3,2'd1,2'd1, 2'd0,2'd2,2'd2, 1'b1, 2'd1,2'd2,2'd2},
        {2'd2,2'd3,2'd3, 2'd2,2'd3,2'd0, 1'b1, 2'd2,2'd3,2'd1},
        {2'd0,2'd0,2'd3, 2'd0,2'd0,2'd3, 1'b0, 2'd3,2'd2,2'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] word_i = '0;
    logic [1:0]        a_mat = '0, a_shape = '0, a_idx = '0;
    logic [1:0]        b_mat = '0, b_shape = '0, b_idx = '0;
    logic [VEC_W-1:0]  res_i = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_mat = '0, wr_shape = '0, wr_idx = '0;
    logic [VEC_W-1:0]  opa_o, opb_o;
    logic [WORD_W-1:0] word_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    opnd_route_switch #(.NMAT(NMAT), .NRX(NRX), .EW(EW), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .word_i(word_i),
        .a_mat(a_mat), .a_shape(a_shape), .a_idx(a_idx),
        .b_mat(b_mat), .b_shape(b_shape), .b_idx(b_idx),
        .res_i(res_i), .wr_en(wr_en), .wr_mat(wr_mat),
        .wr_shape(wr_shape), .wr_idx(wr_idx),
        .opa_o(opa_o), .opb_o(opb_o), .word_o(word_o)
    );

    // Element value: imaginary high half, real low half (R2 layout)
    function automatic logic [CW-1:0] elv(int seed, int m, int r, int c);
        logic [EW-1:0] re, im;
        re = EW'(seed * 3 + m * 64 + r * 8 + c * 2 + 1);
        im = EW'(16'h4000 + seed * 7 + m * 37 + r * 5 + c);
        return {im, re};
    endfunction

    function automatic logic [WORD_W-1:0] mk_word(int seed);
        logic [WORD_W-1:0] w;
        for (int m = 0; m < NMAT; m++)
            for (int r = 0; r < NRX; r++)
                for (int c = 0; c < NRX; c++)
                    w[((m * NRX + r) * NRX + c) * CW +: CW] = elv(seed, m, r, c);
        return w;
    endfunction

    function automatic logic [VEC_W-1:0] mk_res(int seed);
        logic [VEC_W-1:0] v;
        for (int k = 0; k < NRX; k++)
            v[k*CW +: CW] = {EW'(16'hA000 + seed * 16 + k), EW'(16'h5000 + k)};
        return v;
    endfunction

    // Row/column of vector lane k for a shape code (R2..R5)
    function automatic int lane_row(int sh, int idx, int k);
        return (sh == 0) ? idx : k;
    endfunction
    function automatic int lane_col(int sh, int idx, int k);
        case (sh)
            0:       return k;
            1:       return idx;
            2:       return k;
            default: return NRX - 1 - k;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] exp_vec(int seed, int m, int sh, int idx);
        logic [VEC_W-1:0] v;
        for (int k = 0; k < NRX; k++)
            v[k*CW +: CW] = elv(seed, m, lane_row(sh, idx, k), lane_col(sh, idx, k));
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word(int seed, logic en, int wm, int sh, int idx);
        logic [WORD_W-1:0] w;
        logic [VEC_W-1:0]  rv;
        w  = mk_word(seed);
        rv = mk_res(seed);
        if (en)
            for (int k = 0; k < NRX; k++)
                w[((wm * NRX + lane_row(sh, idx, k)) * NRX + lane_col(sh, idx, k)) * CW +: CW]
                    = rv[k*CW +: CW];
        return w;
    endfunction

    function automatic string sh_tag(int sh);
        case (sh)
            0:       return "R2 row";
            1:       return "R3 column";
            2:       return "R4 diagonal";
            default: return "R5 anti-diagonal";
        endcase
    endfunction

    task automatic chk_vec(string tag, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_word(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            for (int e = 0; e < NMAT * NRX * NRX; e++)
                if (act[e*CW +: CW] !== exp[e*CW +: CW]) begin
                    $display("FAIL %s: element %0d actual %h expected %h",
                             tag, e, act[e*CW +: CW], exp[e*CW +: CW]);
                    break;
                end
        end
    endtask

    task automatic apply(int seed, logic [18:0] v);
        word_i   = mk_word(seed);
        res_i    = mk_res(seed);
        {a_mat, a_shape, a_idx, b_mat, b_shape, b_idx, wr_en, wr_mat, wr_shape, wr_idx} = v;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [VEC_W-1:0] prev_a;

        // R1: reset clears registered outputs even with live inputs
        apply(1, TV[0]);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_vec("R1 reset opa", opa_o, '0);
        chk_vec("R1 reset opb", opb_o, '0);
        chk_word("R1 reset word", word_o, '0);
        rst = 1'b0;

        // Table walk: R2..R10, one edge of latency
        for (int t = 0; t < NTV; t++) begin
            @(negedge clk);
            apply(t + 2, TV[t]);
            @(negedge clk);
            chk_vec({sh_tag(int'(a_shape)), " R6 port A"}, opa_o,
                    exp_vec(t + 2, int'(a_mat), int'(a_shape), int'(a_idx)));
            chk_vec({sh_tag(int'(b_shape)), " R7 port B"}, opb_o,
                    exp_vec(t + 2, int'(b_mat), int'(b_shape), int'(b_idx)));
            chk_word(wr_en ? "R8/R9 merge" : "R10 pass-through", word_o,
                     exp_word(t + 2, wr_en, int'(wr_mat), int'(wr_shape), int'(wr_idx)));
        end

        // R11: old value holds until the capturing edge
        @(negedge clk);
        prev_a = opa_o;
        apply(40, {2'd3,2'd0,2'd2, 2'd1,2'd3,2'd0, 1'b0, 2'd0,2'd0,2'd0});
        @(posedge clk);
        #1;
        chk_vec("R11 new after edge", opa_o, exp_vec(40, 3, 0, 2));
        @(negedge clk);
        apply(41, {2'd0,2'd1,2'd0, 2'd1,2'd3,2'd0, 1'b0, 2'd0,2'd0,2'd0});
        prev_a = opa_o;
        #5;
        chk_vec("R11 hold before edge", opa_o, prev_a);
        @(negedge clk);
        chk_vec("R11 column after edge", opa_o, exp_vec(41, 0, 1, 0));

        // R4/R5: index field ignored for diagonal shapes
        @(negedge clk);
        apply(42, {2'd1,2'd2,2'd3, 2'd2,2'd3,2'd2, 1'b1, 2'd1,2'd2,2'd1});
        @(negedge clk);
        chk_vec("R4 diagonal idx ignored", opa_o, exp_vec(42, 1, 2, 0));
        chk_vec("R5 anti-diagonal idx ignored", opb_o, exp_vec(42, 2, 3, 0));
        chk_word("R8 diagonal write idx ignored", word_o, exp_word(42, 1'b1, 1, 2, 0));

        // R1: reset in mid-traffic
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_vec("R1 mid reset opa", opa_o, '0);
        chk_word("R1 mid reset word", word_o, '0);
        rst = 1'b0;

        finish_run();
    end
endmodule